// File: doc/BRIEF.md
# Receive Character Buffer with Error Status and Flow Control

This block is the holding stage behind the receiver of one asynchronous serial channel. A receiver front end delivers complete characters. Each character comes with three flags: framing error, parity error and break. The block keeps up to eight characters in arrival order and presents the oldest one, with its status, to a host. The host removes that character with a one-cycle read strobe. If a character completes while all eight slots are taken, one more character is parked in a single holding slot until room appears. Anything beyond that is lost, and a sticky overrun flag records the loss.

Status can be reported in two ways, selected by a mode input. Per-character reporting shows only the flags of the character at the head. Accumulated reporting shows the OR of the flags of every character that has reached the head since the last clear. Two commands clear state, each given with a one-cycle command strobe and a 4-bit code. The error-clear command (code 0x4) clears the accumulated flags and the overrun flag. The receiver-clear command (code 0x2) empties the whole buffer and clears all flags.

An active-low request-to-send output supports hardware flow control. It normally follows an output-port enable bit. When automatic control is enabled, a start bit seen while the buffer is full forces the line inactive. The line comes back once the host frees a slot. The enable bit itself is never changed by this action.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the block is empty: `rx_ready`=0, `fifo_full`=0, `overrun`=0, `rd_stat`=0, and `rts_n` equals the inverse of `rts_port_bit`.
- R2: Characters leave in arrival order. A pop on an empty buffer does nothing. Up to 8 characters are stored; `rx_ready` is high when at least one is stored, and `fifo_full` is high when 8 are stored. A character offered on `char_valid` becomes visible at the head in the following cycle.
- R3: With `err_mode`=0, `rd_stat` shows the flags of the head character only, with bit 0 = framing, bit 1 = parity and bit 2 = break. It reads 0 when the buffer is empty.
- R4: With `err_mode`=1, `rd_stat` is the OR of the flags of the current head and of every character that has been at the head since the last clear.
- R5: The error-clear command (`cmd_valid` with `cmd_code`=0x4) clears the accumulated flags and `overrun` at the next edge. It leaves the stored characters untouched.
- R6: The parity flag is stored only when `parity_mode` is 00 or 01. With 10 or 11 it is stored as 0.
- R7: A character that completes while the buffer is full goes to a holding slot. It enters the buffer on the first pop and is never lost on its own.
- R8: A character that completes while the buffer is full and the holding slot is occupied is discarded, and `overrun` rises at the next edge. The flag stays high until a clear.
- R9: With `rts_ctrl`=1 and `rts_port_bit`=1, a `start_det` while the buffer is full and no pop takes place drives `rts_n` high from the next cycle.
- R10: An effective pop releases the forced state, so `rts_n` returns to the inverse of `rts_port_bit` from the next cycle. With `rts_port_bit`=0, `rts_n` is always high.
- R11: The receiver-clear command (`cmd_valid` with `cmd_code`=0x2) empties the buffer and the holding slot, clears all flags and releases the forced request-to-send state. It takes priority over every other input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 4 | Command code: 0x2 receiver clear, 0x4 error clear, others ignored |
| err_mode | input | 1 | 0 per-character status, 1 accumulated status |
| parity_mode | input | 2 | 00 checked, 01 forced, 10 none, 11 multi-drop |
| rts_ctrl | input | 1 | Enables automatic request-to-send control |
| rts_port_bit | input | 1 | Output-port bit that asserts request-to-send |
| start_det | input | 1 | Front end saw a valid start bit |
| char_valid | input | 1 | A complete character is offered |
| char_data | input | DW (8) | Character data |
| char_fe | input | 1 | Framing error of the offered character |
| char_pe | input | 1 | Parity error of the offered character |
| char_brk | input | 1 | Break flag of the offered character |
| rd_pop | input | 1 | Host removes the head character |
| rd_data | output | DW (8) | Head character data |
| rd_stat | output | 3 | Reported status {break, parity, framing} |
| rx_ready | output | 1 | At least one character stored |
| fifo_full | output | 1 | All 8 slots stored |
| overrun | output | 1 | A character was discarded |
| rts_n | output | 1 | Active-low request to send |

## Verification
If the occupancy count is wrong, it shows within one cycle on `rx_ready` or `fifo_full`. A pointer slip shows on `rd_data` at the next pop, as a character out of order or repeated. An accumulator that fails to hold its value, or that fails to clear, changes `rd_stat` in accumulated mode in the cycle after the head moves on or after a clear. Faults in the holding slot or in the request-to-send forced state show one edge after the pop or start bit that should have moved them: as a missing character at the tail of the drained sequence, a false or missing `overrun`, or a wrong `rts_n` level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef logic [2:0] rx_stat_t;

  localparam int ST_FE  = 0;
  localparam int ST_PE  = 1;
  localparam int ST_BRK = 2;

  localparam logic [3:0] CMD_RX_CLEAR  = 4'h2;
  localparam logic [3:0] CMD_ERR_CLEAR = 4'h4;

  // Parity is checked only in modes 00 and 01.
  function automatic logic parity_checked(logic [1:0] pmode);
    return !pmode[1];
  endfunction

  function automatic rx_stat_t pack_stat(logic fe, logic pe, logic brk, logic [1:0] pmode);
    rx_stat_t s;
    s = '0;
    s[ST_FE]  = fe;
    s[ST_PE]  = pe & parity_checked(pmode);
    s[ST_BRK] = brk;
    return s;
  endfunction

  function automatic rx_stat_t merge_stat(rx_stat_t a, rx_stat_t b);
    return a | b;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  rx_stat_t                     wr_stat,
  input  logic                         rd_en,
  output logic [DW-1:0]                head_data,
  output rx_stat_t                     head_stat,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_d [DEPTH];
  rx_stat_t      mem_s [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_ptr == AW'(i)) begin
        mem_d[i] <= wr_data;
        mem_s[i] <= wr_stat;
      end
    end
  end

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign count     = cnt;
  assign head_data = mem_d[rd_ptr];
  assign head_stat = empty ? '0 : mem_s[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R2
  AST_WRITE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |-> (!full || rd_en)); // R2
  AST_READ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R2
  AST_EMPTY_POP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en && !clr) |=> empty); // R2
endmodule

// File: rtl/rxf_admit.sv
module rxf_admit
  import rxf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          char_valid,
  input  logic [DW-1:0] char_data,
  input  rx_stat_t      char_stat,
  input  logic          full,
  input  logic          pop,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output rx_stat_t      wr_stat,
  output logic          lose,
  output logic          hold_busy
);
  logic          hold_v, nxt_v;
  logic [DW-1:0] hold_d, nxt_d;
  rx_stat_t      hold_s, nxt_s;
  logic          space;

  assign space = !full || pop;

  always_comb begin
    wr_en   = 1'b0;
    wr_data = hold_d;
    wr_stat = hold_s;
    lose    = 1'b0;
    nxt_v   = hold_v;
    nxt_d   = hold_d;
    nxt_s   = hold_s;
    if (hold_v) begin
      if (space) begin
        wr_en = 1'b1;
        nxt_v = 1'b0;
      end
      if (char_valid) begin
        if (space) begin
          nxt_v = 1'b1;
          nxt_d = char_data;
          nxt_s = char_stat;
        end else begin
          lose = 1'b1;
        end
      end
    end else if (char_valid) begin
      if (space) begin
        wr_en   = 1'b1;
        wr_data = char_data;
        wr_stat = char_stat;
      end else begin
        nxt_v = 1'b1;
        nxt_d = char_data;
        nxt_s = char_stat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      hold_s <= '0;
    end else begin
      hold_v <= nxt_v;
      hold_d <= nxt_d;
      hold_s <= nxt_s;
    end
  end

  assign hold_busy = hold_v;

  AST_HOLD_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !space && !clr) |=> hold_v); // R7
  AST_LOSE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lose |-> (hold_v && full && !pop)); // R8
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     block_mode,
  input  rx_stat_t head_stat,
  input  logic     lose,
  output rx_stat_t rep_stat,
  output logic     overrun
);
  rx_stat_t acc_q;
  logic     ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= merge_stat(acc_q, head_stat);
      ovr_q <= ovr_q | lose;
    end
  end

  assign rep_stat = block_mode ? merge_stat(acc_q, head_stat) : head_stat;
  assign overrun  = ovr_q;

  AST_ACC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R4
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !overrun)); // R5
  AST_OVR_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (lose && !clr) |=> overrun); // R8
endmodule

// File: rtl/rxf_flow.sv
module rxf_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start_det,
  input  logic full,
  input  logic pop,
  input  logic rts_ctrl,
  input  logic rts_en,
  output logic rts_n
);
  logic drop_q;
  logic drop_evt;

  assign drop_evt = start_det && full && rts_ctrl && rts_en && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  drop_q <= 1'b0;
    else if (pop)       drop_q <= 1'b0;
    else if (drop_evt)  drop_q <= 1'b1;
  end

  assign rts_n = !rts_en || (drop_q && rts_ctrl);

  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !clr) |=> (rts_n || !rts_ctrl)); // R9
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |=> (rts_n == !rts_en)); // R10
  AST_RTS_PORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |-> rts_n); // R10
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_code,
  input  logic          err_mode,
  input  logic [1:0]    parity_mode,
  input  logic          rts_ctrl,
  input  logic          rts_port_bit,
  input  logic          start_det,
  input  logic          char_valid,
  input  logic [DW-1:0] char_data,
  input  logic          char_fe,
  input  logic          char_pe,
  input  logic          char_brk,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    rd_stat,
  output logic          rx_ready,
  output logic          fifo_full,
  output logic          overrun,
  output logic          rts_n
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_clr, err_clr, flag_clr;
  rx_stat_t      in_stat, wr_stat, head_stat, rep_stat;
  logic          empty, full, pop_eff;
  logic          wr_en, lose, hold_busy;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] count;

  assign rx_clr   = cmd_valid && (cmd_code == CMD_RX_CLEAR);
  assign err_clr  = cmd_valid && (cmd_code == CMD_ERR_CLEAR);
  assign flag_clr = rx_clr || err_clr;
  assign in_stat  = pack_stat(char_fe, char_pe, char_brk, parity_mode);
  assign pop_eff  = rd_pop && !empty;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
    .rd_en(pop_eff), .head_data(rd_data), .head_stat(head_stat),
    .count(count), .empty(empty), .full(full)
  );

  rxf_admit #(.DW(DW)) u_admit (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .char_valid(char_valid), .char_data(char_data), .char_stat(in_stat),
    .full(full), .pop(pop_eff),
    .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
    .lose(lose), .hold_busy(hold_busy)
  );

  rxf_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr),
    .block_mode(err_mode), .head_stat(head_stat), .lose(lose),
    .rep_stat(rep_stat), .overrun(overrun)
  );

  rxf_flow u_flow (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .start_det(start_det), .full(full), .pop(pop_eff),
    .rts_ctrl(rts_ctrl), .rts_en(rts_port_bit), .rts_n(rts_n)
  );

  assign rd_stat   = rep_stat;
  assign rx_ready  = !empty;
  assign fifo_full = full;

  AST_HOLD_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |-> fifo_full); // R7
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (!rx_ready && !overrun && count == '0 && !hold_busy)); // R11
  AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_ready); // R2
  AST_EMPTY_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !err_mode) |-> (rd_stat == '0)); // R3
endmodule

// File: tb/sim_rx_hold_fifo.sv
`timescale 1ns/1ps
module sim_rx_hold_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic       err_mode = 1'b0;
  logic [1:0] parity_mode = 2'b00;
  logic       rts_ctrl = 1'b1;
  logic       rts_port_bit = 1'b1;
  logic       start_det = 1'b0;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = 8'h00;
  logic       char_fe = 1'b0, char_pe = 1'b0, char_brk = 1'b0;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] rd_stat;
  logic       rx_ready, fifo_full, overrun, rts_n;

  always #5 clk = ~clk;

  rx_hold_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .err_mode(err_mode), .parity_mode(parity_mode), .rts_ctrl(rts_ctrl),
    .rts_port_bit(rts_port_bit), .start_det(start_det), .char_valid(char_valid),
    .char_data(char_data), .char_fe(char_fe), .char_pe(char_pe), .char_brk(char_brk),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_stat(rd_stat), .rx_ready(rx_ready),
    .fifo_full(fifo_full), .overrun(overrun), .rts_n(rts_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [10:0] mq[$];
  bit         m_hold_v;
  logic [10:0] m_hold;
  logic [2:0] m_acc;
  bit         m_ovr, m_drop;

  // pending configuration, applied inside cyc()
  logic       c_mode = 1'b0;
  logic [1:0] c_pm = 2'b00;
  logic       c_ctrl = 1'b1;
  logic       c_en = 1'b1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_head();
    return (mq.size() > 0) ? mq[0][10:8] : 3'b000;
  endfunction

  function automatic logic [2:0] ref_stat();
    return err_mode ? (m_acc | ref_head()) : ref_head();
  endfunction

  function automatic logic ref_rts();
    return !rts_port_bit || (m_drop && rts_ctrl);
  endfunction

  function automatic logic [2:0] ref_pack(logic fe, logic pe, logic brk, logic [1:0] pm);
    logic pe_k;
    pe_k = (pm == 2'b00 || pm == 2'b01) ? pe : 1'b0;
    return {brk, pe_k, fe};
  endfunction

  task automatic compare();
    check(rx_ready == (mq.size() > 0), "R2", "rx_ready", rx_ready, mq.size() > 0);
    check(fifo_full == (mq.size() == 8), "R2", "fifo_full", fifo_full, mq.size() == 8);
    if (mq.size() > 0)
      check(rd_data == mq[0][7:0], "R2", "rd_data", rd_data, mq[0][7:0]);
    if (err_mode)
      check(rd_stat == ref_stat(), "R4", "rd_stat block", rd_stat, ref_stat());
    else
      check(rd_stat == ref_stat(), "R3", "rd_stat char", rd_stat, ref_stat());
    check(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
    if (m_drop)
      check(rts_n == ref_rts(), "R9", "rts_n forced", rts_n, ref_rts());
    else
      check(rts_n == ref_rts(), "R10", "rts_n follow", rts_n, ref_rts());
  endtask

  task automatic step();
    bit rxc, errc, pop, space, lose, full_now;
    logic [2:0] head_now;
    logic [10:0] nw;
    rxc  = cmd_valid && cmd_code == 4'h2;
    errc = cmd_valid && cmd_code == 4'h4;
    if (!rst_n || rxc) begin
      mq.delete();
      m_hold_v = 0; m_acc = 0; m_ovr = 0; m_drop = 0;
      return;
    end
    pop = rd_pop && mq.size() > 0;
    full_now = (mq.size() == 8);
    head_now = ref_head();
    if (pop) m_drop = 0;
    else if (start_det && full_now && rts_ctrl && rts_port_bit) m_drop = 1;
    nw = {ref_pack(char_fe, char_pe, char_brk, parity_mode), char_data};
    if (pop) void'(mq.pop_front());
    space = (mq.size() < 8);
    lose = 0;
    if (m_hold_v) begin
      if (space) begin mq.push_back(m_hold); m_hold_v = 0; end
      if (char_valid) begin
        if (space) begin m_hold = nw; m_hold_v = 1; end
        else lose = 1;
      end
    end else if (char_valid) begin
      if (space) mq.push_back(nw);
      else begin m_hold = nw; m_hold_v = 1; end
    end
    m_acc = errc ? 3'b000 : (m_acc | head_now);
    m_ovr = errc ? 1'b0 : (m_ovr | lose);
  endtask

  task automatic cyc(bit cv, bit pop, bit st, bit cmv, logic [3:0] code, logic [2:0] sb);
    @(negedge clk);
    compare();
    err_mode = c_mode; parity_mode = c_pm; rts_ctrl = c_ctrl; rts_port_bit = c_en;
    char_valid = cv; char_data = 8'($urandom);
    char_fe = sb[0]; char_pe = sb[1]; char_brk = sb[2];
    rd_pop = pop; start_det = st; cmd_valid = cmv; cmd_code = code;
    step();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 4'h0, 3'b000);
  endtask

  function automatic logic [2:0] rnd_stat();
    logic [2:0] s;
    for (int b = 0; b < 3; b++) s[b] = ($urandom % 4 == 0);
    return s;
  endfunction

  task automatic run_random(int n, int p_char, int p_pop, int p_start, int p_cmd);
    for (int i = 0; i < n; i++) begin
      bit cmv;
      logic [3:0] code;
      int r;
      cmv = ($urandom % 1000) < p_cmd;
      r = $urandom % 10;
      code = (r < 6) ? 4'h4 : (r < 8) ? 4'h2 : 4'h7;
      cyc(($urandom % 100) < p_char, ($urandom % 100) < p_pop,
          ($urandom % 100) < p_start, cmv, code, rnd_stat());
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9127));
    step();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(rx_ready == 0, "R1", "rx_ready after reset", rx_ready, 0);
    check(fifo_full == 0, "R1", "fifo_full after reset", fifo_full, 0);
    check(overrun == 0, "R1", "overrun after reset", overrun, 0);
    check(rd_stat == 0, "R1", "rd_stat after reset", rd_stat, 0);
    check(rts_n == 0, "R1", "rts_n after reset", rts_n, 0);

    // fill the buffer
    for (int i = 0; i < 8; i++) cyc(1, 0, 1, 0, 4'h0, 3'b000);
    idle();
    check(fifo_full == 1, "R2", "full after 8 chars", fifo_full, 1);
    check(rts_n == 0, "R9", "rts_n before start bit", rts_n, 0);
    // start bit while full
    cyc(0, 0, 1, 0, 4'h0, 3'b000);
    idle();
    check(rts_n == 1, "R9", "rts_n after start bit on full", rts_n, 1);
    // ninth character parked
    cyc(1, 0, 0, 0, 4'h0, 3'b000);
    idle();
    check(overrun == 0, "R7", "no overrun for parked char", overrun, 0);
    // tenth character lost
    cyc(1, 0, 0, 0, 4'h0, 3'b000);
    idle();
    check(overrun == 1, "R8", "overrun after tenth char", overrun, 1);
    // pop: parked character moves in
    cyc(0, 1, 0, 0, 4'h0, 3'b000);
    idle();
    check(fifo_full == 1, "R7", "parked char refills slot", fifo_full, 1);
    check(rts_n == 0, "R10", "rts_n released after pop", rts_n, 0);
    // error clear keeps data
    cyc(0, 0, 0, 1, 4'h4, 3'b000);
    idle();
    check(overrun == 0, "R5", "overrun cleared", overrun, 0);
    check(fifo_full == 1, "R5", "data kept over error clear", fifo_full, 1);
    // drain fully; order checked by compare()
    for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0, 4'h0, 3'b000);
    idle();
    check(rx_ready == 0, "R2", "empty after drain", rx_ready, 0);
    cyc(0, 1, 0, 0, 4'h0, 3'b000);
    idle();
    check(rx_ready == 0, "R2", "pop on empty ignored", rx_ready, 0);

    // parity masking
    c_pm = 2'b10;
    cyc(1, 0, 0, 0, 4'h0, 3'b010);
    idle();
    check(rd_stat[1] == 0, "R6", "parity dropped in mode 10", rd_stat[1], 0);
    cyc(0, 0, 0, 1, 4'h2, 3'b000);
    c_pm = 2'b01;
    cyc(1, 0, 0, 0, 4'h0, 3'b010);
    idle();
    check(rd_stat[1] == 1, "R6", "parity kept in mode 01", rd_stat[1], 1);
    // receiver clear with content
    cyc(1, 0, 0, 1, 4'h2, 3'b111);
    idle();
    check(rx_ready == 0, "R11", "rx clear empties", rx_ready, 0);
    check(rd_stat == 0, "R11", "rx clear status", rd_stat, 0);

    // accumulated status
    c_mode = 1'b1; c_pm = 2'b00;
    cyc(1, 0, 0, 0, 4'h0, 3'b001);
    cyc(1, 0, 0, 0, 4'h0, 3'b100);
    cyc(1, 0, 0, 0, 4'h0, 3'b000);
    idle();
    cyc(0, 1, 0, 0, 4'h0, 3'b000);
    cyc(0, 1, 0, 0, 4'h0, 3'b000);
    idle();
    check(rd_stat == 3'b101, "R4", "accumulated flags", rd_stat, 3'b101);
    cyc(0, 0, 0, 1, 4'h4, 3'b000);
    idle();
    check(rd_stat == 3'b000, "R5", "accumulated flags cleared", rd_stat, 0);
    c_mode = 1'b0;
    idle();
    cyc(0, 0, 0, 1, 4'h2, 3'b000);

    // random phases over configurations
    for (int ph = 0; ph < 8; ph++) begin
      c_mode = ph[0];
      c_ctrl = ph[1];
      c_en   = (ph != 5);
      c_pm   = 2'($urandom);
      if (ph[2]) run_random(1500, 45, 20, 30, 8);
      else       run_random(1500, 35, 40, 20, 15);
    end
    idle();
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule